// File: doc/BRIEF.md
# Contact Smart Card Power Sequencer

This block orders the power-up and power-down of a contact smart card under the control of a host. A single active-low command line opens and closes a card session. On opening, the block enables the charge-pump stage and the card supply regulator, then the card data lines, then the card clock, and finally lets the card reset follow the host's reset request. On closing, it takes the same steps back in reverse order. All steps are placed on a grid of half time units, where one time unit is a parameterised number of internal oscillator cycles (64 by default).

During a session, the block watches the card-presence contacts, an overcurrent flag and an overtemperature flag. Any of these starts an emergency power-down and pulls the active-low status line low. That fault indication is held until the host releases the command line. A loss of the logic supply also powers the card down, but it leaves the status line high. Outside a session, the status line simply reports whether a card is inserted. After the supply becomes good, a hold-off window keeps the block inactive whatever the command line does.

The clock can start in two ways. If the host reset request is high when the session opens, the clock is held until that request falls, which gives the host an exact count of clock pulses before reset is released.

Top module: `card_power_seq`

## Requirements
- R1: After reset, and again each time `supply_ok` returns high, all card enables stay low for GUARD_TICKS cycles. A command request that is low during that window, or still low when the window ends, starts no session.
- R2: A session starts when `cmd_n` is low in the idle state with a card present. `vup_en` and `vcc_en` rise together two cycles after `cmd_n` is sampled low. `io_en` rises 4 time units (8 half units) later.
- R3: If `rst_req` is low when the session starts, `clk_en` rises in the same cycle as `io_en`.
- R4: If `rst_req` is high when the session starts, `clk_en` stays low until `rst_req` falls. When it falls between the 4T and 7T steps, `clk_en` rises one cycle after the fall. If it never falls, `clk_en` is forced high at the 7T step. `card_rst` stays low before 7T and copies `rst_req` one cycle later after that.
- R5: When `cmd_n` rises, the outputs turn off in this order: `card_rst` first, then `clk_en` T/2 later, `io_en` at T, `vcc_en` at 1.5T and `vup_en` at 5T. The times are measured from the cycle `card_rst` falls, with a two-cycle lag after the command edge.
- R6: A card counts as present when `pres_n` is 0 or `pres` is 1. Outside a session, `status_n` equals the presence value, with one cycle of lag.
- R7: Card removal, `over_cur` or `over_temp` during a session starts the R5 power-down sequence. The event is sampled one cycle after it occurs. `status_n` then goes low and stays low, even if the card is reinserted, until `cmd_n` goes high.
- R8: A low `supply_ok` during a session starts the R5 power-down sequence, and `status_n` stays high.
- R9: Once a session has ended, a new session needs `cmd_n` to be seen high in the idle state first. A request made during power-down, or held low through it, is ignored. So is a request made with no card present.
- R10: At all times a lower stage is on only when the stage above it is on. `vcc_en` implies `vup_en`, `io_en` implies `vcc_en`, `clk_en` implies `io_en`, and `card_rst` implies `clk_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_n | input | 1 | Host session command, active low |
| rst_req | input | 1 | Host card-reset request, active high |
| pres_n | input | 1 | Presence contact, active low |
| pres | input | 1 | Presence contact, active high |
| over_cur | input | 1 | Card supply overcurrent flag |
| over_temp | input | 1 | Overtemperature flag |
| supply_ok | input | 1 | Logic supply good |
| vup_en | output | 1 | Charge-pump enable |
| vcc_en | output | 1 | Card supply regulator enable |
| io_en | output | 1 | Card data line enable |
| clk_en | output | 1 | Card clock enable |
| card_rst | output | 1 | Reset to card |
| status_n | output | 1 | Status / interrupt, active low |

## Verification
The bench builds the block with TICKS_PER_T = 8 and GUARD_TICKS = 20. A full session then takes about a hundred cycles, and the hold-off window is short enough to be entered and left many times in one run. At this size, every step of both timelines can be compared to the exact cycle: the clock started by a reset fall, the forced start at the 7T step, and emergency power-downs from removal, overtemperature, overcurrent and supply loss. It also becomes practical to show that requests made during the hold-off or during power-down are ignored.

// File: rtl/cps_pkg.sv
package cps_pkg;
  typedef enum logic [2:0] {
    S_GUARD,
    S_IDLE,
    S_ACT,
    S_ON,
    S_DEACT
  } seq_state_t;

  // step numbers counted in half time units
  localparam int STEP_W     = 4;
  localparam int IO_STEP    = 8;   // data lines enabled at 4T
  localparam int ON_STEP    = 14;  // reset gating at 7T
  localparam int CLK_OFF    = 1;   // clock stop at T/2
  localparam int IO_OFF     = 2;   // data lines released at T
  localparam int VCC_OFF    = 3;   // supply ramp down from 1.5T
  localparam int VUP_OFF    = 10;  // charge pump stop at 5T
endpackage

// File: rtl/cps_timebase.sv
module cps_timebase #(
  parameter int HALF_T = 32,
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  output logic [STEP_W-1:0] step
);
  localparam int HW = (HALF_T > 1) ? $clog2(HALF_T) : 1;
  localparam logic [HW-1:0] HALF_LAST = HW'(HALF_T - 1);

  logic [HW-1:0] half_cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      half_cnt <= '0;
      step     <= '0;
    end else if (half_cnt == HALF_LAST) begin
      half_cnt <= '0;
      if (step != '1) step <= step + 1'b1;
    end else begin
      half_cnt <= half_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cps_guard.sv
module cps_guard #(
  parameter int GUARD_TICKS = 25600
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic supply_ok,
  output logic done
);
  localparam int GW = $clog2(GUARD_TICKS + 1);
  localparam logic [GW-1:0] LIMIT = GW'(GUARD_TICKS);

  logic [GW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !enable || !supply_ok) cnt <= '0;
    else if (cnt != LIMIT)            cnt <= cnt + 1'b1;
  end

  assign done = supply_ok && (cnt == LIMIT);
endmodule

// File: rtl/cps_status.sv
module cps_status (
  input  logic clk,
  input  logic rst,
  input  logic cmd_n,
  input  logic pres_n,
  input  logic pres,
  input  logic over_cur,
  input  logic over_temp,
  input  logic start,
  input  logic powered,
  output logic present,
  output logic fault_now,
  output logic status_n
);
  logic session, fault;

  assign present   = !pres_n || pres;
  assign fault_now = !present || over_cur || over_temp;

  always_ff @(posedge clk) begin
    if (rst) begin
      session  <= 1'b0;
      fault    <= 1'b0;
      status_n <= 1'b0;
    end else begin
      if (cmd_n)      session <= 1'b0;
      else if (start) session <= 1'b1;

      if (cmd_n)                       fault <= 1'b0;
      else if (powered && fault_now)   fault <= 1'b1;

      status_n <= session ? !fault : present;
    end
  end
endmodule

// File: rtl/cps_sequencer.sv
module cps_sequencer
  import cps_pkg::*;
#(
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_n,
  input  logic              rst_req,
  input  logic              supply_ok,
  input  logic              present,
  input  logic              fault_now,
  input  logic              guard_done,
  input  logic [STEP_W-1:0] step,
  output logic              start,
  output logic              restart,
  output logic              powered,
  output logic              in_guard,
  output logic              vup_en,
  output logic              vcc_en,
  output logic              io_en,
  output logic              clk_en,
  output logic              card_rst
);
  localparam logic [STEP_W-1:0] IO_S  = STEP_W'(IO_STEP);
  localparam logic [STEP_W-1:0] ON_S  = STEP_W'(ON_STEP);
  localparam logic [STEP_W-1:0] CK_O  = STEP_W'(CLK_OFF);
  localparam logic [STEP_W-1:0] IO_O  = STEP_W'(IO_OFF);
  localparam logic [STEP_W-1:0] VC_O  = STEP_W'(VCC_OFF);
  localparam logic [STEP_W-1:0] VU_O  = STEP_W'(VUP_OFF);

  seq_state_t state, state_nx;
  logic armed, hold_clk, stop;

  assign powered  = (state == S_ACT) || (state == S_ON);
  assign in_guard = (state == S_GUARD);
  assign start    = (state == S_IDLE) && armed && !cmd_n && present && supply_ok;
  assign stop     = powered && (cmd_n || !supply_ok || fault_now);
  assign restart  = start || stop;

  always_comb begin
    state_nx = state;
    unique case (state)
      S_GUARD: if (guard_done) state_nx = S_IDLE;
      S_IDLE:  if (!supply_ok) state_nx = S_GUARD;
               else if (start) state_nx = S_ACT;
      S_ACT:   if (stop) state_nx = S_DEACT;
               else if (step == ON_S) state_nx = S_ON;
      S_ON:    if (stop) state_nx = S_DEACT;
      S_DEACT: if (step == VU_O) state_nx = S_IDLE;
      default: state_nx = S_GUARD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_GUARD;
      armed    <= 1'b0;
      hold_clk <= 1'b0;
      vup_en   <= 1'b0;
      vcc_en   <= 1'b0;
      io_en    <= 1'b0;
      clk_en   <= 1'b0;
      card_rst <= 1'b0;
    end else begin
      state <= state_nx;
      if (start)                        armed <= 1'b0;
      else if (state == S_IDLE && cmd_n) armed <= 1'b1;
      if (start) hold_clk <= rst_req;

      unique case (state)
        S_ACT: begin
          vup_en   <= 1'b1;
          vcc_en   <= 1'b1;
          io_en    <= (step >= IO_S);
          clk_en   <= clk_en || (step >= ON_S) ||
                      ((step >= IO_S) && (!hold_clk || !rst_req));
          card_rst <= 1'b0;
        end
        S_ON: begin
          vup_en   <= 1'b1;
          vcc_en   <= 1'b1;
          io_en    <= 1'b1;
          clk_en   <= 1'b1;
          card_rst <= rst_req;
        end
        S_DEACT: begin
          card_rst <= 1'b0;
          clk_en   <= clk_en && (step < CK_O);
          io_en    <= io_en  && (step < IO_O);
          vcc_en   <= vcc_en && (step < VC_O);
          vup_en   <= vup_en && (step < VU_O);
        end
        default: begin
          vup_en   <= 1'b0;
          vcc_en   <= 1'b0;
          io_en    <= 1'b0;
          clk_en   <= 1'b0;
          card_rst <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/card_power_seq.sv
module card_power_seq #(
  parameter int TICKS_PER_T = 64,
  parameter int GUARD_TICKS = 25600
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd_n,
  input  logic rst_req,
  input  logic pres_n,
  input  logic pres,
  input  logic over_cur,
  input  logic over_temp,
  input  logic supply_ok,
  output logic vup_en,
  output logic vcc_en,
  output logic io_en,
  output logic clk_en,
  output logic card_rst,
  output logic status_n
);
  localparam int HALF_T = TICKS_PER_T / 2;
  localparam int SW     = cps_pkg::STEP_W;

  logic [SW-1:0] step;
  logic start, restart, powered, in_guard, guard_done, present, fault_now;

  cps_timebase #(.HALF_T(HALF_T), .STEP_W(SW)) u_tb (
    .clk(clk), .rst(rst), .restart(restart), .step(step)
  );

  cps_guard #(.GUARD_TICKS(GUARD_TICKS)) u_guard (
    .clk(clk), .rst(rst), .enable(in_guard), .supply_ok(supply_ok),
    .done(guard_done)
  );

  cps_status u_stat (
    .clk(clk), .rst(rst), .cmd_n(cmd_n), .pres_n(pres_n), .pres(pres),
    .over_cur(over_cur), .over_temp(over_temp), .start(start),
    .powered(powered), .present(present), .fault_now(fault_now),
    .status_n(status_n)
  );

  cps_sequencer #(.STEP_W(SW)) u_seq (
    .clk(clk), .rst(rst), .cmd_n(cmd_n), .rst_req(rst_req),
    .supply_ok(supply_ok), .present(present), .fault_now(fault_now),
    .guard_done(guard_done), .step(step), .start(start),
    .restart(restart), .powered(powered), .in_guard(in_guard),
    .vup_en(vup_en), .vcc_en(vcc_en), .io_en(io_en), .clk_en(clk_en),
    .card_rst(card_rst)
  );
endmodule

// File: rtl/cps_checker.sv
module cps_checker (
  input logic clk,
  input logic rst,
  input logic cmd_n,
  input logic vup_en,
  input logic vcc_en,
  input logic io_en,
  input logic clk_en,
  input logic card_rst
);
  assert_vcc_under_vup_R10: assert property (@(posedge clk) disable iff (rst)
    vcc_en |-> vup_en);
  assert_io_under_vcc_R10: assert property (@(posedge clk) disable iff (rst)
    io_en |-> vcc_en);
  assert_clk_under_io_R10: assert property (@(posedge clk) disable iff (rst)
    clk_en |-> io_en);
  assert_rst_under_clk_R10: assert property (@(posedge clk) disable iff (rst)
    card_rst |-> clk_en);
  assert_start_needs_cmd_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(vup_en) |-> ($past(cmd_n, 2) == 1'b0));
  assert_pump_last_off_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(vup_en) |-> !vcc_en && !io_en && !clk_en);
endmodule

bind card_power_seq cps_checker u_chk (
  .clk(clk), .rst(rst), .cmd_n(cmd_n), .vup_en(vup_en), .vcc_en(vcc_en),
  .io_en(io_en), .clk_en(clk_en), .card_rst(card_rst)
);

// File: tb/sim_card_power_seq.sv
module sim_card_power_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TPT   = 8;
  localparam int GUARD = 20;
  localparam int H     = TPT / 2;
  localparam int TOL   = 1;

  typedef struct { int sig; bit val; int at; string req; } ev_t;

  logic clk = 0, rst = 1;
  logic cmd_n = 1, rst_req = 0, pres_n = 0, pres = 0;
  logic over_cur = 0, over_temp = 0, supply_ok = 1;
  logic vup_en, vcc_en, io_en, clk_en, card_rst, status_n;

  int cyc = 0, n_chk = 0, n_bad = 0;
  bit mon_on = 0, finished = 0;
  ev_t q[$];
  logic [4:0] prev;

  card_power_seq #(.TICKS_PER_T(TPT), .GUARD_TICKS(GUARD)) u0 (
    .clk(clk), .rst(rst), .cmd_n(cmd_n), .rst_req(rst_req), .pres_n(pres_n),
    .pres(pres), .over_cur(over_cur), .over_temp(over_temp),
    .supply_ok(supply_ok), .vup_en(vup_en), .vcc_en(vcc_en), .io_en(io_en),
    .clk_en(clk_en), .card_rst(card_rst), .status_n(status_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic void push(int sig, bit val, int at, string req);
    ev_t e;
    e.sig = sig; e.val = val; e.at = at; e.req = req;
    q.push_back(e);
  endfunction

  // monitor: compare each output change against the expected queue
  always @(negedge clk) begin
    logic [4:0] now;
    now = {card_rst, clk_en, io_en, vcc_en, vup_en};
    if (mon_on) begin
      for (int i = 0; i < 5; i++) begin
        if (now[i] != prev[i]) begin
          n_chk++;
          if (q.size() == 0) begin
            n_bad++;
            $display("FAIL R9 unexpected change sig%0d actual=%0b expected=none at %0d", i, now[i], cyc);
          end else begin
            ev_t e;
            e = q.pop_front();
            if (e.sig != i || e.val != now[i] || cyc > e.at + TOL || cyc < e.at - TOL) begin
              n_bad++;
              $display("FAIL %s sig%0d=%0b at %0d, expected sig%0d=%0b at %0d",
                       e.req, i, now[i], cyc, e.sig, e.val, e.at);
            end
          end
        end
      end
    end
    prev = now;
  end

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0d", req, act, exp, cyc);
    end
  endtask

  task automatic to_cyc(int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drained(string req);
    n_chk++;
    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL %s pending=%0d expected=0 at %0d", req, q.size(), cyc);
      q.delete();
    end
  endtask

  // activation: returns the cycle the command was dropped
  task automatic activate(bit rq, output int s);
    @(negedge clk);
    rst_req = rq; cmd_n = 0; s = cyc;
    push(0, 1, s + 2, "R2"); push(1, 1, s + 2, "R2");
    push(2, 1, s + 2 + 8*H, "R2");
    if (!rq) push(3, 1, s + 2 + 8*H, "R3");
  endtask

  task automatic expect_off(int d, bit rst_on, string req);
    if (rst_on) push(4, 0, d + 2, req);
    push(3, 0, d + 2 + 1*H, req);
    push(2, 0, d + 2 + 2*H, req);
    push(1, 0, d + 2 + 3*H, req);
    push(0, 0, d + 2 + 10*H, req);
  endtask

  initial begin
    int s, d;
    repeat (3) @(negedge clk);
    rst = 0;
    prev = '0; mon_on = 1;
    @(negedge clk);
    chk("R1 reset vup", vup_en, 0);
    chk("R6 reset status present", status_n, 1);
    // R1: request inside the guard window is ignored
    cmd_n = 0; wait_n(6); cmd_n = 1;
    wait_n(GUARD + 5);
    chk("R1 guard ignore", vup_en, 0);
    // R6 presence polarity
    pres_n = 1; pres = 0; wait_n(2); chk("R6 absent", status_n, 0);
    pres = 1; wait_n(2); chk("R6 present high contact", status_n, 1);
    pres = 0; pres_n = 0; wait_n(2); chk("R6 present low contact", status_n, 1);
    // R9: request with no card
    pres_n = 1; wait_n(2); cmd_n = 0; wait_n(12);
    chk("R9 no card vup", vup_en, 0);
    chk("R6 no card status", status_n, 0);
    cmd_n = 1; pres_n = 0; wait_n(3);

    // R2/R3 normal session, reset following, then R5 power-down
    activate(0, s);
    to_cyc(s + 70); rst_req = 1; push(4, 1, cyc + 1, "R4");
    wait_n(5); rst_req = 0; push(4, 0, cyc + 1, "R4");
    wait_n(3); rst_req = 1; push(4, 1, cyc + 1, "R4");
    wait_n(5);
    chk("R6 session status", status_n, 1);
    @(negedge clk); cmd_n = 1; d = cyc; expect_off(d, 1, "R5");
    wait_n(10*H + 8); drained("R5"); rst_req = 0;
    chk("R6 after session", status_n, 1);

    // R4 clock released by reset fall
    activate(1, s);
    to_cyc(s + 44); rst_req = 0; push(3, 1, cyc + 1, "R4");
    to_cyc(s + 80);
    chk("R4 reset stays low", card_rst, 0);
    @(negedge clk); cmd_n = 1; d = cyc; expect_off(d, 0, "R5");
    wait_n(10*H + 8); drained("R4");

    // R4 reset never falls: forced clock at 7T, reset copied after
    activate(1, s);
    push(3, 1, s + 2 + 14*H, "R4"); push(4, 1, s + 3 + 14*H, "R4");
    to_cyc(s + 75);
    @(negedge clk); cmd_n = 1; d = cyc; expect_off(d, 1, "R5");
    wait_n(10*H + 8); drained("R4 forced"); rst_req = 0;

    // R7 removal, latched status
    activate(0, s);
    to_cyc(s + 70); pres_n = 1; d = cyc; expect_off(d, 0, "R7");
    wait_n(3); chk("R7 removal status", status_n, 0);
    wait_n(4); pres_n = 0; wait_n(3);
    chk("R7 latched after reinsert", status_n, 0);
    wait_n(10*H + 8); drained("R7");
    chk("R9 no restart while low", vup_en, 0);
    chk("R7 held until cmd high", status_n, 0);
    cmd_n = 1; wait_n(3); chk("R7 released", status_n, 1);

    // R7 overtemperature with command kept low (R9)
    activate(0, s);
    to_cyc(s + 70); over_temp = 1; d = cyc; expect_off(d, 0, "R7");
    wait_n(2); over_temp = 0; wait_n(2);
    chk("R7 overtemp status", status_n, 0);
    wait_n(10*H + 20); drained("R7 temp");
    chk("R9 held low no restart", vup_en, 0);
    cmd_n = 1; wait_n(3);

    // R9 request made during power-down is ignored
    activate(0, s);
    to_cyc(s + 70); cmd_n = 1; d = cyc; expect_off(d, 0, "R5");
    wait_n(10); cmd_n = 0;
    wait_n(10*H + 20); drained("R9");
    chk("R9 request during off", vup_en, 0);
    cmd_n = 1; wait_n(3);

    // R8 supply drop, then R1 guard after return
    activate(0, s);
    to_cyc(s + 70); supply_ok = 0; d = cyc; expect_off(d, 0, "R8");
    wait_n(3); chk("R8 status stays high", status_n, 1);
    wait_n(10*H + 8); drained("R8");
    cmd_n = 1; wait_n(2); supply_ok = 1; wait_n(2); cmd_n = 0;
    wait_n(GUARD + 15);
    chk("R1 guard after supply", vup_en, 0);
    cmd_n = 1; wait_n(3);

    // R7 overcurrent
    activate(0, s);
    to_cyc(s + 70); over_cur = 1; d = cyc; expect_off(d, 0, "R7");
    wait_n(3); over_cur = 0;
    chk("R7 overcurrent status", status_n, 0);
    wait_n(10*H + 8); drained("R7 cur");
    cmd_n = 1; wait_n(3);
    chk("R6 final status", status_n, 1);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule